// File: doc/BRIEF.md
# Pretrigger Ring-Buffer Capture Controller

This block records a wide probe vector into on-chip memory at one sample per clock. Software or a sequencer arms it. While armed in ring mode it writes samples without stopping and keeps only the most recent ones, up to a programmed pretrigger length. A selectable start event begins the real recording. That event can be a trigger pulse, the rising edge of the design-under-test run signal, or a manual start pulse. Recording ends on a second trigger, after a programmed number of cycles, or when memory is full.

After capture the block holds its samples. A host pulls them out in time order, oldest first, one per read request, over a simple read port with a valid flag and a last flag. A separate live output always shows the probe vector of the previous cycle. This lets a host poll the current samples directly, whether or not a recording is running.

Top module: `pretrig_capture`

## Requirements
- R1: After reset, `capState` is 0 (idle), `validCount` is 0 and `rdValid` is 0.
- R2: `armReq` in idle moves `capState` to 1 (armed) on the next cycle with `validCount` 0. `armReq` in any other state has no effect on state or on the stored samples.
- R3: `startSel` picks the start event: 0 = `trigIn` high, 1 = rising edge of `dutRun`, 2 = `manualStart` high, 3 = none. While armed, events that are not selected are ignored. On the start cycle, `capState` becomes 2 (recording), and that cycle's probe value is the first post-start sample.
- R4: While armed with `ringMode` high, the number of retained pre-start samples equals the smallest of: the armed cycles before the start, `preCount`, and DEPTH-1. With `ringMode` low, none are retained.
- R5: With `stopSel` 0, a `trigIn` pulse in a cycle after the start cycle stores that cycle's sample and ends the recording.
- R6: With `stopSel` 1, recording ends after `recCount` post-start samples, with at least one sample taken.
- R7: Recording always ends once DEPTH samples are held. With `stopSel` 2 or 3, this is the only stop condition.
- R8: When recording ends, `capState` becomes 3 (done) and `validCount` equals the pretrigger samples plus the post-start samples.
- R9: In done, each cycle with `rdReq` high returns the next stored sample, oldest first. The sample appears on `rdData` with `rdValid` high one cycle later, and `rdLast` marks the final sample. After the final read, the state returns to idle. `rdReq` outside done produces no `rdValid`.
- R10: `liveData` equals the probe value of the previous cycle in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| probe | input | W | Sampled vector |
| trigIn | input | 1 | Trigger pulse from the trigger logic |
| dutRun | input | 1 | Run level of the design under test |
| manualStart | input | 1 | Manual start pulse |
| armReq | input | 1 | Arm command |
| ringMode | input | 1 | Keep pre-start samples while armed |
| startSel | input | 2 | Start event select |
| stopSel | input | 2 | Stop condition select |
| preCount | input | log2(DEPTH)+1 | Pretrigger length in cycles |
| recCount | input | log2(DEPTH)+1 | Post-start length in cycles (timer stop) |
| rdReq | input | 1 | Read request for the next stored sample |
| rdData | output | W | Read sample |
| rdValid | output | 1 | rdData holds a sample |
| rdLast | output | 1 | Sample on rdData is the final one |
| liveData | output | W | Probe value of the previous cycle |
| capState | output | 2 | 0 idle, 1 armed, 2 recording, 3 done |
| validCount | output | log2(DEPTH)+1 | Samples held |

## Verification
State changes, `validCount` and `liveData` update on the clock edge that samples the stimulus. A read answers on the edge that samples `rdReq`. Every result is therefore due one edge after the input that causes it. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. It notes the edge index of every driven probe value, so it can compute from those indices the stop edge, the sample count and the expected sample for each read.

// File: rtl/pretrig_pkg.sv
package pretrig_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_REC   = 2'd2,
    CAP_DONE  = 2'd3
  } capState_t;

  typedef struct packed {
    logic wrEn;
    logic clearPtr;
    logic loadRd;
    logic rdEn;
  } capStrobe_t;
endpackage

// File: rtl/pretrig_ctrl.sv
module pretrig_ctrl
  import pretrig_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       trigIn,
  input  logic                       dutRun,
  input  logic                       manualStart,
  input  logic                       armReq,
  input  logic                       ringMode,
  input  logic [1:0]                 startSel,
  input  logic [1:0]                 stopSel,
  input  logic [$clog2(DEPTH):0]     preCount,
  input  logic [$clog2(DEPTH):0]     recCount,
  input  logic                       rdReq,
  output capStrobe_t                 strobe,
  output logic [$clog2(DEPTH):0]     backoff,
  output logic [1:0]                 capState,
  output logic [$clog2(DEPTH):0]     validCount,
  output logic                       rdLast
);
  localparam int LW = $clog2(DEPTH) + 1;
  localparam logic [LW-1:0] FULL_L = LW'(DEPTH);
  localparam logic [LW-1:0] PRE_MAX = LW'(DEPTH - 1);

  capState_t stateQ, stateD;
  logic [LW-1:0] countQ, countD, recQ, recD, remQ;
  logic [LW-1:0] preLim;
  logic dutRunQ, startHit, stopNow, lastQ;

  always_comb begin
    unique case (startSel)
      2'd0:    startHit = trigIn;
      2'd1:    startHit = dutRun & ~dutRunQ;
      2'd2:    startHit = manualStart;
      default: startHit = 1'b0;
    endcase
  end

  assign preLim = (preCount > PRE_MAX) ? PRE_MAX : preCount;

  always_comb begin
    strobe   = '0;
    stateD   = stateQ;
    countD   = countQ;
    recD     = recQ;
    stopNow  = 1'b0;
    unique case (stateQ)
      CAP_IDLE: begin
        if (armReq) begin
          stateD          = CAP_ARMED;
          countD          = '0;
          recD            = '0;
          strobe.clearPtr = 1'b1;
        end
      end
      CAP_ARMED: begin
        if (startHit) begin
          strobe.wrEn = 1'b1;
          countD      = countQ + 1'b1;
          recD        = LW'(1);
          stateD      = CAP_REC;
        end else if (ringMode) begin
          strobe.wrEn = 1'b1;
          if (countQ < preLim) countD = countQ + 1'b1;
        end
      end
      CAP_REC: begin
        strobe.wrEn = 1'b1;
        countD      = countQ + 1'b1;
        recD        = recQ + 1'b1;
      end
      default: begin
        strobe.rdEn = rdReq && (remQ != '0);
        if (strobe.rdEn && remQ == LW'(1)) stateD = CAP_IDLE;
      end
    endcase
    if (stateD == CAP_REC) begin
      stopNow = (countD == FULL_L)
             || (stopSel == 2'd1 && recD >= recCount)
             || (stopSel == 2'd0 && stateQ == CAP_REC && trigIn);
      if (stopNow) begin
        stateD        = CAP_DONE;
        strobe.loadRd = 1'b1;
      end
    end
  end

  assign backoff = countD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= CAP_IDLE;
      countQ  <= '0;
      recQ    <= '0;
      remQ    <= '0;
      dutRunQ <= 1'b0;
      lastQ   <= 1'b0;
    end else begin
      stateQ  <= stateD;
      countQ  <= countD;
      recQ    <= recD;
      dutRunQ <= dutRun;
      lastQ   <= strobe.rdEn && (remQ == LW'(1));
      if (strobe.loadRd)    remQ <= countD;
      else if (strobe.rdEn) remQ <= remQ - 1'b1;
    end
  end

  assign capState   = stateQ;
  assign validCount = countQ;
  assign rdLast     = lastQ;
endmodule

// File: rtl/pretrig_datapath.sv
module pretrig_datapath
  import pretrig_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 1024
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [W-1:0]           probe,
  input  capStrobe_t             strobe,
  input  logic [$clog2(DEPTH):0] backoff,
  output logic [W-1:0]           rdData,
  output logic                   rdValid,
  output logic [W-1:0]           liveData
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[wrPtr] <= probe;
    if (strobe.rdEn) rdData <= mem[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      rdValid  <= 1'b0;
      liveData <= '0;
    end else begin
      liveData <= probe;
      rdValid  <= strobe.rdEn;
      if (strobe.clearPtr)  wrPtr <= '0;
      else if (strobe.wrEn) wrPtr <= wrPtr + 1'b1;
      if (strobe.loadRd)    rdPtr <= wrPtr + AW'(1) - backoff[AW-1:0];
      else if (strobe.rdEn) rdPtr <= rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture
  import pretrig_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 1024
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [W-1:0]           probe,
  input  logic                   trigIn,
  input  logic                   dutRun,
  input  logic                   manualStart,
  input  logic                   armReq,
  input  logic                   ringMode,
  input  logic [1:0]             startSel,
  input  logic [1:0]             stopSel,
  input  logic [$clog2(DEPTH):0] preCount,
  input  logic [$clog2(DEPTH):0] recCount,
  input  logic                   rdReq,
  output logic [W-1:0]           rdData,
  output logic                   rdValid,
  output logic                   rdLast,
  output logic [W-1:0]           liveData,
  output logic [1:0]             capState,
  output logic [$clog2(DEPTH):0] validCount
);
  capStrobe_t strobe;
  logic [$clog2(DEPTH):0] backoff;

  pretrig_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .dutRun(dutRun),
    .manualStart(manualStart), .armReq(armReq), .ringMode(ringMode),
    .startSel(startSel), .stopSel(stopSel), .preCount(preCount),
    .recCount(recCount), .rdReq(rdReq), .strobe(strobe), .backoff(backoff),
    .capState(capState), .validCount(validCount), .rdLast(rdLast)
  );

  pretrig_datapath #(.W(W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .probe(probe), .strobe(strobe),
    .backoff(backoff), .rdData(rdData), .rdValid(rdValid),
    .liveData(liveData)
  );
endmodule

// File: rtl/pretrig_checker.sv
module pretrig_checker #(
  parameter int W     = 32,
  parameter int DEPTH = 1024
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [W-1:0]           probe,
  input logic                   armReq,
  input logic                   rdReq,
  input logic                   rdValid,
  input logic                   rdLast,
  input logic [W-1:0]           liveData,
  input logic [1:0]             capState,
  input logic [$clog2(DEPTH):0] validCount
);
  assert_arm_R2: assert property (@(posedge clk) disable iff (!rstN)
    (capState == 2'd0 && armReq) |=> (capState == 2'd1 && validCount == '0));

  assert_done_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (capState == 2'd3 && !rdReq) |=> (capState == 2'd3 && $stable(validCount)));

  assert_armed_room_R4: assert property (@(posedge clk) disable iff (!rstN)
    (capState == 2'd1) |-> (validCount < ($clog2(DEPTH)+1)'(DEPTH)));

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    validCount <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_read_in_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(capState) == 2'd3);

  assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |-> rdValid);

  assert_live_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> liveData == $past(probe));
endmodule

bind pretrig_capture pretrig_checker #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .probe(probe), .armReq(armReq), .rdReq(rdReq),
  .rdValid(rdValid), .rdLast(rdLast), .liveData(liveData),
  .capState(capState), .validCount(validCount)
);

// File: tb/test_pretrig_capture.sv
module test_pretrig_capture;
  localparam int W = 32;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH) + 1;
  localparam int HM = 16383;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] probe = '0;
  logic trigIn = 0, dutRun = 0, manualStart = 0, armReq = 0, ringMode = 0, rdReq = 0;
  logic [1:0] startSel = 0, stopSel = 0;
  logic [LW-1:0] preCount = 0, recCount = 1;
  logic [W-1:0] rdData, liveData;
  logic rdValid, rdLast;
  logic [1:0] capState;
  logic [LW-1:0] validCount;

  int checks = 0, errors = 0, cyc = 0, lastEdge = 0;
  logic [W-1:0] hist [0:HM];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pretrig_capture #(.W(W), .DEPTH(DEPTH)) i_pretrig_capture (
    .clk(clk), .rstN(rstN), .probe(probe), .trigIn(trigIn), .dutRun(dutRun),
    .manualStart(manualStart), .armReq(armReq), .ringMode(ringMode),
    .startSel(startSel), .stopSel(stopSel), .preCount(preCount),
    .recCount(recCount), .rdReq(rdReq), .rdData(rdData), .rdValid(rdValid),
    .rdLast(rdLast), .liveData(liveData), .capState(capState),
    .validCount(validCount)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Drive at a falling edge, pass one rising edge, return at the next falling edge.
  task automatic step(input bit arm, input bit trg, input bit dut, input bit man, input bit rd);
    armReq = arm; trigIn = trg; dutRun = dut; manualStart = man; rdReq = rd;
    probe = $urandom;
    lastEdge = cyc + 1;
    hist[lastEdge & HM] = probe;
    @(negedge clk);
    chk(liveData == hist[lastEdge & HM], "R10 live", liveData, hist[lastEdge & HM]);
  endtask

  task automatic scen(input bit ring, input int pre, input int ssel, input int psel,
                      input int rec, input int waitN, input int stopAfter);
    int s, e, preExp, eExp, tot;
    string stopTag;
    ringMode = ring; preCount = LW'(pre); startSel = 2'(ssel);
    stopSel = 2'(psel); recCount = LW'(rec);
    stopTag = (psel == 0) ? "R5 stop trig" : (psel == 1) ? "R6 stop timer" : "R7 stop full";
    step(1, 0, 0, 0, 0);
    chk(capState == 2'd1, "R2 arm", capState, 1);
    chk(validCount == 0, "R2 arm count", validCount, 0);
    for (int w = 0; w < waitN; w++) begin
      step(w == 1, (ssel != 0) ? 1'($urandom) : 1'b0, 1'b0,
           (ssel != 2) ? 1'($urandom) : 1'b0, 1'b0);
      chk(capState == 2'd1, "R3 unselected ignored", capState, 1);
    end
    step(0, ssel == 0, ssel == 1, ssel == 2, 0);
    s = lastEdge;
    preExp = ring ? imin(waitN, imin(pre, DEPTH - 1)) : 0;
    eExp = s + (DEPTH - preExp) - 1;
    if (psel == 1) eExp = imin(eExp, s + rec - 1);
    if (psel == 0) eExp = imin(eExp, s + stopAfter);
    e = -1;
    if (capState == 2'd3) e = s;
    else chk(capState == 2'd2, "R3 start", capState, 2);
    for (int k = 1; k <= 40 && e < 0; k++) begin
      step(0, (psel == 0) ? (k == stopAfter) : 1'($urandom), ssel == 1, 1'($urandom), 0);
      if (capState == 2'd3) e = lastEdge;
    end
    chk(e == eExp, stopTag, e - s, eExp - s);
    tot = preExp + eExp - s + 1;
    chk(validCount == LW'(tot), "R8 count", validCount, tot);
    step(1, 0, ssel == 1, 0, 0);
    chk(capState == 2'd3, "R2 arm ignored in done", capState, 3);
    chk(validCount == LW'(tot), "R2 count kept", validCount, tot);
    for (int i = 0; i < tot; i++) begin
      step(0, 0, 0, 0, 1);
      chk(rdValid == 1'b1, "R9 valid", rdValid, 1);
      chk(rdData == hist[(s - preExp + i) & HM], (preExp > 0) ? "R4 data" : "R9 data",
          rdData, hist[(s - preExp + i) & HM]);
      chk(rdLast == (i == tot - 1), "R9 last", rdLast, (i == tot - 1));
    end
    step(0, 0, 0, 0, 0);
    chk(capState == 2'd0, "R9 back to idle", capState, 0);
    step(0, 0, 0, 0, 1);
    chk(rdValid == 1'b0, "R9 read outside done", rdValid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(capState == 2'd0, "R1 reset state", capState, 0);
    chk(validCount == 0, "R1 reset count", validCount, 0);
    chk(rdValid == 1'b0, "R1 reset valid", rdValid, 0);
    rstN = 1'b1;
    step(0, 0, 0, 0, 0);
    // directed corners
    scen(1, 8, 0, 0, 1, 2, 3);    // trigger before pretrigger fills (R4)
    scen(1, 20, 2, 2, 1, 20, 1);  // pretrigger saturates, full on start cycle (R7)
    scen(1, 5, 1, 1, 1, 9, 1);    // timer of one sample (R6)
    scen(0, 6, 2, 1, 7, 4, 1);    // non-ring keeps nothing (R4)
    scen(0, 0, 0, 2, 1, 3, 1);    // full after DEPTH samples (R7)
    scen(1, 3, 1, 0, 1, 6, 2);    // second trigger after dut start (R5)
    for (int n = 0; n < 30; n++)
      scen($urandom % 2, $urandom % 21, $urandom % 3, $urandom % 3,
           1 + $urandom % 20, $urandom % 21, 1 + $urandom % 20);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule